// File: doc/BRIEF.md
# Segment LCD Event Flag and Interrupt Unit

This block keeps the four event flags of a segment LCD controller and folds them into a single interrupt request. A frame-boundary strobe sets the frame flag directly. Blink-clock edges and the ends of animation steps and loops are held as pending events until the next frame boundary. Each one takes effect only at that boundary.

Blink edges drive an internal blink phase. The phase is either "normal", meaning segments are lit and the main memory is shown, or "alternate", meaning segments are dark or the blink memory is shown. Every aligned edge flips the phase. The blink-return flag is raised when the phase comes back to normal.

Flags clear by themselves as a side effect of writes to the display, blink or animation memory. Software can also clear them by writing ones to the status register. The status vector is the register read path. The interrupt request is the registered OR of the flags, each masked by its own enable bit.

Top module: `lcd_irq_flags`

## Requirements
- R1: After reset, `status` is 0, `irq` is 0 and the blink phase is normal.
- R2: Status bit 0 (frame flag) is 1 in the cycle after any cycle with `frame_tick` high.
- R3: A `blink_edge` pulse is held pending until the next cycle with `frame_tick` high, counting that cycle itself. At that point the blink phase flips. Status bit 1 (blink-return flag) sets when the flip returns the phase to normal, for `blink_mode` 2'b01, 2'b10 and 2'b11.
- R4: While `blink_mode` is 2'b00, status bit 1 never sets, the blink phase is forced to normal and any pending blink edge is discarded.
- R5: An `anim_step_end` pulse is held pending until the next frame boundary and then sets status bit 2. While `anim_en` is 0, the pending step event is discarded and bit 2 does not set.
- R6: An `anim_loop_end` pulse behaves the same way for status bit 3, also gated by `anim_en`.
- R7: A write to the display memory (`wr_disp_mem`) or to the blink memory (`wr_blink_mem`) clears status bits 0 and 1 and leaves bits 2 and 3 unchanged.
- R8: A write to the animation memory (`wr_anim_mem`) clears status bits 2 and 3 and leaves bits 0 and 1 unchanged.
- R9: With `sw_clr_we` high, each bit of `status` whose matching `sw_clr_data` bit is 1 clears.
- R10: When a flag's set event and any of its clear sources occur in the same cycle, the flag ends up 1.
- R11: `irq` equals the OR of `status & irq_en` from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle frame-boundary strobe |
| blink_edge | input | 1 | One-cycle blink-clock edge strobe |
| blink_mode | input | 2 | Blink mode: 00 off, 01/10 segment blink, 11 memory swap |
| anim_en | input | 1 | Animation enable |
| anim_step_end | input | 1 | End of animation step strobe |
| anim_loop_end | input | 1 | End of animation loop strobe |
| irq_en | input | 4 | Per-flag interrupt enables, same bit order as `status` |
| wr_disp_mem | input | 1 | Display memory write strobe |
| wr_blink_mem | input | 1 | Blink memory write strobe |
| wr_anim_mem | input | 1 | Animation memory write strobe |
| sw_clr_we | input | 1 | Status register write strobe (write-one-to-clear) |
| sw_clr_data | input | 4 | Status register write data |
| status | output | 4 | Flags: bit0 frame, bit1 blink-return, bit2 anim step, bit3 anim loop |
| irq | output | 1 | Registered interrupt request |

## Verification
Sparse random strobes under every blink mode separate correct phase tracking from an implementation that flags every aligned edge. Toggling `anim_en` while step and loop events are pending shows whether gated events are dropped or leak through. Memory writes and software clears are made to collide with frame boundaries. This catches any priority that lets a clear win over a set, and any auto-clear that reaches the wrong flag group. Directed runs cover mode 00 with pending edges, two-edge blink cycles, and a clear-on-write that must leave the other flag group alone.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int MODE_W    = 2;
  localparam int ANIM_EVTS = 2;

  typedef enum logic [1:0] {
    FLG_FRAME  = 2'd0,
    FLG_BLINK  = 2'd1,
    FLG_STEP   = 2'd2,
    FLG_LOOP   = 2'd3
  } flag_idx_e;

  typedef enum logic [MODE_W-1:0] {
    BLK_NONE   = 2'b00,
    BLK_SEG_A  = 2'b01,
    BLK_SEG_B  = 2'b10,
    BLK_SWAP   = 2'b11
  } blink_mode_e;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/lcd_evt_align.sv
module lcd_evt_align
  import lcd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              blink_edge,
  input  logic [MODE_W-1:0] blink_mode,
  input  logic              anim_en,
  input  logic              anim_step_end,
  input  logic              anim_loop_end,
  output flag_vec_t         set_vec
);
  // Blink phase: 0 = normal (lit / main memory), 1 = alternate.
  logic phase_q, phase_d;
  logic bpend_q, bpend_d;
  logic blink_set;
  logic blink_active;
  logic bpend_now;

  assign blink_active = (blink_mode != BLK_NONE);
  assign bpend_now    = bpend_q | blink_edge;

  always_comb begin
    phase_d   = phase_q;
    bpend_d   = bpend_now;
    blink_set = 1'b0;
    if (!blink_active) begin
      phase_d = 1'b0;
      bpend_d = 1'b0;
    end else if (frame_tick && bpend_now) begin
      phase_d   = ~phase_q;
      bpend_d   = 1'b0;
      blink_set = phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      bpend_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bpend_q <= bpend_d;
    end
  end

  // Animation events: held until frame boundary, dropped when disabled.
  logic [ANIM_EVTS-1:0] anim_strb;
  logic [ANIM_EVTS-1:0] apend_q, apend_d;
  logic [ANIM_EVTS-1:0] anim_set;

  assign anim_strb = {anim_loop_end, anim_step_end};

  for (genvar g = 0; g < ANIM_EVTS; g++) begin : g_anim
    logic pend_now;
    assign pend_now = apend_q[g] | anim_strb[g];

    always_comb begin
      apend_d[g]  = pend_now;
      anim_set[g] = 1'b0;
      if (!anim_en) begin
        apend_d[g] = 1'b0;
      end else if (frame_tick && pend_now) begin
        apend_d[g]  = 1'b0;
        anim_set[g] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) apend_q[g] <= 1'b0;
      else        apend_q[g] <= apend_d[g];
    end
  end

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_FRAME] = frame_tick;
    set_vec[FLG_BLINK] = blink_set;
    set_vec[FLG_STEP]  = anim_set[0];
    set_vec[FLG_LOOP]  = anim_set[1];
  end
endmodule

// File: rtl/lcd_flag_bank.sv
module lcd_flag_bank
  import lcd_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  output flag_vec_t flags
);
  flag_vec_t flg_q, flg_d, flg_ce;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_comb begin
      flg_ce[i] = set_vec[i] | clr_vec[i];
      flg_d[i]  = set_vec[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flg_q[i] <= 1'b0;
      else if (flg_ce[i]) flg_q[i] <= flg_d[i];
    end
  end

  assign flags = flg_q;
endmodule

// File: rtl/lcd_irq_merge.sv
module lcd_irq_merge
  import lcd_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t flags,
  input  flag_vec_t enables,
  output logic      irq
);
  logic irq_q, irq_d;

  always_comb irq_d = |(flags & enables);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/lcd_irq_flags.sv
module lcd_irq_flags
  import lcd_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic                 blink_edge,
  input  logic [1:0]           blink_mode,
  input  logic                 anim_en,
  input  logic                 anim_step_end,
  input  logic                 anim_loop_end,
  input  logic [3:0]           irq_en,
  input  logic                 wr_disp_mem,
  input  logic                 wr_blink_mem,
  input  logic                 wr_anim_mem,
  input  logic                 sw_clr_we,
  input  logic [3:0]           sw_clr_data,
  output logic [3:0]           status,
  output logic                 irq
);
  flag_vec_t set_vec;
  flag_vec_t clr_vec;
  flag_vec_t flags;
  logic      disp_grp_wr;

  lcd_evt_align u_align (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_tick    (frame_tick),
    .blink_edge    (blink_edge),
    .blink_mode    (blink_mode),
    .anim_en       (anim_en),
    .anim_step_end (anim_step_end),
    .anim_loop_end (anim_loop_end),
    .set_vec       (set_vec)
  );

  assign disp_grp_wr = wr_disp_mem | wr_blink_mem;

  always_comb begin
    clr_vec            = sw_clr_we ? sw_clr_data : '0;
    clr_vec[FLG_FRAME] = clr_vec[FLG_FRAME] | disp_grp_wr;
    clr_vec[FLG_BLINK] = clr_vec[FLG_BLINK] | disp_grp_wr;
    clr_vec[FLG_STEP]  = clr_vec[FLG_STEP]  | wr_anim_mem;
    clr_vec[FLG_LOOP]  = clr_vec[FLG_LOOP]  | wr_anim_mem;
  end

  lcd_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  lcd_irq_merge u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .enables (irq_en),
    .irq     (irq)
  );

  assign status = flags;
endmodule

// File: rtl/lcd_irq_flags_chk.sv
module lcd_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick,
  input logic [1:0] blink_mode,
  input logic       anim_en,
  input logic [3:0] irq_en,
  input logic       wr_disp_mem,
  input logic       wr_blink_mem,
  input logic       wr_anim_mem,
  input logic [3:0] status,
  input logic       irq
);
  AST_FRAME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> status[0]); // R2

  AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_mode == 2'b00 && !status[1]) |=> !status[1]); // R4

  AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!anim_en && !status[2]) |=> !status[2]); // R5

  AST_LOOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!anim_en && !status[3]) |=> !status[3]); // R6

  AST_DISP_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_disp_mem || wr_blink_mem) && !frame_tick) |=> (status[1:0] == 2'b00)); // R7

  AST_ANIM_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_anim_mem && !frame_tick) |=> (status[3:2] == 2'b00)); // R8

  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(status & irq_en))); // R11
endmodule

bind lcd_irq_flags lcd_irq_flags_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_tick   (frame_tick),
  .blink_mode   (blink_mode),
  .anim_en      (anim_en),
  .irq_en       (irq_en),
  .wr_disp_mem  (wr_disp_mem),
  .wr_blink_mem (wr_blink_mem),
  .wr_anim_mem  (wr_anim_mem),
  .status       (status),
  .irq          (irq)
);

// File: tb/lcd_irq_flags_test.sv
`timescale 1ns/1ps
module lcd_irq_flags_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_tick, blink_edge, anim_en, anim_step_end, anim_loop_end;
  logic [1:0] blink_mode;
  logic [3:0] irq_en, sw_clr_data, status;
  logic       wr_disp_mem, wr_blink_mem, wr_anim_mem, sw_clr_we, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state
  logic       m_phase, m_bpend, m_spend, m_lpend, m_irq;
  logic [3:0] m_flags;

  always #10 clk = ~clk; // 50 MHz

  lcd_irq_flags uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_sets();
    logic [3:0] s;
    s = 4'b0;
    s[0] = frame_tick;
    if (blink_mode != 2'b00 && frame_tick && (m_bpend | blink_edge)) s[1] = m_phase;
    if (anim_en && frame_tick && (m_spend | anim_step_end)) s[2] = 1'b1;
    if (anim_en && frame_tick && (m_lpend | anim_loop_end)) s[3] = 1'b1;
    return s;
  endfunction

  task automatic model_update();
    logic [3:0] s, c;
    s = model_sets();
    c = sw_clr_we ? sw_clr_data : 4'b0;
    c = c | {wr_anim_mem, wr_anim_mem, {2{wr_disp_mem | wr_blink_mem}}};
    m_irq = |(m_flags & irq_en);
    m_flags = s | (m_flags & ~c);
    if (blink_mode == 2'b00) begin
      m_phase = 1'b0; m_bpend = 1'b0;
    end else if (frame_tick && (m_bpend | blink_edge)) begin
      m_phase = ~m_phase; m_bpend = 1'b0;
    end else m_bpend = m_bpend | blink_edge;
    if (!anim_en) begin m_spend = 1'b0; m_lpend = 1'b0; end
    else begin
      m_spend = frame_tick ? 1'b0 : (m_spend | anim_step_end);
      m_lpend = frame_tick ? 1'b0 : (m_lpend | anim_loop_end);
    end
  endtask

  task automatic idle();
    frame_tick = 0; blink_edge = 0; anim_step_end = 0; anim_loop_end = 0;
    wr_disp_mem = 0; wr_blink_mem = 0; wr_anim_mem = 0;
    sw_clr_we = 0; sw_clr_data = 4'b0;
  endtask

  // Inputs are already set (after a negedge); advance one edge and compare.
  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    #2;
    check({tag, " status"}, {28'b0, status}, {28'b0, m_flags});
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
    @(negedge clk);
    idle();
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1CD5EED));
    idle();
    blink_mode = 2'b01; anim_en = 1; irq_en = 4'hF;
    rst_n = 0;
    m_phase = 0; m_bpend = 0; m_spend = 0; m_lpend = 0; m_irq = 0; m_flags = 0;
    repeat (3) @(negedge clk);
    check("R1 status", {28'b0, status}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R3: two aligned edges, flag only on return to normal phase
    blink_edge = 1; step("R3 edge1");
    frame_tick = 1; step("R3 frame1");
    check("R3 no flag on first flip", {31'b0, status[1]}, 32'h0);
    blink_edge = 1; frame_tick = 1; step("R3 frame2");
    check("R3 flag on return", {31'b0, status[1]}, 32'h1);
    step("R11 irq follows");
    check("R11 irq high", {31'b0, irq}, 32'h1);

    // R7: display write clears bits 1:0 only; first load anim flags
    anim_step_end = 1; anim_loop_end = 1; step("R5 pend");
    frame_tick = 1; step("R6 frame");
    check("R6 anim flags set", {30'b0, status[3:2]}, 32'h3);
    wr_blink_mem = 1; step("R7 wr");
    check("R7 after write", {28'b0, status}, 32'hC);
    wr_anim_mem = 1; step("R8 wr");
    check("R8 after write", {28'b0, status}, 32'h0);

    // R4: mode 00 with pending edges never flags
    blink_mode = 2'b00;
    for (int k = 0; k < 6; k++) begin
      blink_edge = 1; frame_tick = (k % 2 == 1); step("R4 mode0");
    end
    check("R4 blink flag low", {31'b0, status[1]}, 32'h0);

    // R5: disabled animation drops a pending step
    anim_en = 1; anim_step_end = 1; step("R5 pend2");
    anim_en = 0; step("R5 drop");
    anim_en = 1; frame_tick = 1; step("R5 frame");
    check("R5 step dropped", {31'b0, status[2]}, 32'h0);

    // R10: set collides with clears
    frame_tick = 1; wr_disp_mem = 1; sw_clr_we = 1; sw_clr_data = 4'hF; step("R10 collide");
    check("R10 frame wins", {31'b0, status[0]}, 32'h1);

    // R9: software clear
    sw_clr_we = 1; sw_clr_data = 4'b0001; step("R9 swclr");
    check("R9 cleared", {31'b0, status[0]}, 32'h0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      string tag;
      if (n % 50 == 0) blink_mode = 2'($urandom_range(0, 3));
      if (n % 40 == 0) irq_en = 4'($urandom);
      if (n % 70 == 0) anim_en = ($urandom_range(0, 3) != 0);
      frame_tick    = ($urandom_range(0, 5) == 0);
      blink_edge    = ($urandom_range(0, 4) == 0);
      anim_step_end = ($urandom_range(0, 6) == 0);
      anim_loop_end = ($urandom_range(0, 12) == 0);
      wr_disp_mem   = ($urandom_range(0, 14) == 0);
      wr_blink_mem  = ($urandom_range(0, 19) == 0);
      wr_anim_mem   = ($urandom_range(0, 14) == 0);
      sw_clr_we     = ($urandom_range(0, 11) == 0);
      sw_clr_data   = 4'($urandom);
      case (n % 6)
        0: tag = "R2 rand";
        1: tag = "R3 rand";
        2: tag = "R5 rand";
        3: tag = "R6 rand";
        4: tag = "R10 rand";
        default: tag = "R11 rand";
      endcase
      step(tag);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule